// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block sequences the addresses of one DMA channel. A 16-bit address counter sits below an 8-bit page register and an 8-bit high-page register, and together they form a 32-bit physical address. A 16-bit down-counter tracks the remaining transfers. Each accepted step strobe advances the address, decrements the count, and on the final transfer raises a one-cycle terminal-count pulse. After that pulse the channel ignores steps until a new count is loaded.

The channel has two transfer widths. In byte mode the address counter supplies physical bits 15:0, so a page spans 64 KB. In word mode the counter supplies physical bits 16:1, bit 0 is zero, and page bit 0 is ignored, so a page spans 128 KB. In word mode the count is in words.

Software sets the channel up through separate write strobes. The high-page write must come last, because it arms the carry path from the address counter into the page registers. Until that write, the address wraps inside its current page.

Top module: `dma_addr_gen`

## Requirements
- R1: After reset, phys_addr is 0 and tc is 0. Steps are ignored until a count is loaded.
- R2: In byte mode (mode value 0), phys_addr equals {high page, page, address counter}.
- R3: In word mode (mode value 1), phys_addr[31:24] is the high page, [23:17] is page[7:1], [16:1] is the address counter and [0] is 0. Page bit 0 has no effect on phys_addr.
- R4: Each accepted step adds one to the address counter. This moves phys_addr by 1 in byte mode and by 2 in word mode.
- R5: A count load of N gives N+1 accepted steps. tc is high for exactly the one cycle after the step that found the count at zero.
- R6: After terminal count, steps have no effect on phys_addr or tc until a count is loaded again.
- R7: While the carry enable is clear, an address-counter wrap from 0xFFFF to 0x0000 leaves the page and high page unchanged.
- R8: A high-page write sets the carry enable. While the enable is set, an address wrap increments the combined {high page, page} value: by 1 in byte mode, and by 2 in word mode, which keeps page bit 0.
- R9: A write to the address or the page clears the carry enable. The clear wins over a high-page write in the same cycle.
- R10: A step in a cycle that carries any register write is ignored.
- R11: The transfer width is taken from mode_wr_val on a mode_wr_en cycle and held until the next mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_en | input | 1 | Mode write strobe |
| mode_wr_val | input | 1 | 0 selects byte mode, 1 selects word mode |
| addr_wr_en | input | 1 | Address counter write strobe |
| addr_wr_val | input | 16 | Initial address counter value |
| cnt_wr_en | input | 1 | Count write strobe; re-arms the channel |
| cnt_wr_val | input | 16 | Transfer count minus one |
| page_wr_en | input | 1 | Page register write strobe |
| page_wr_val | input | 8 | Page value |
| hipage_wr_en | input | 1 | High-page write strobe; sets carry enable |
| hipage_wr_val | input | 8 | High-page value |
| step | input | 1 | Transfer strobe |
| phys_addr | output | 32 | Physical address of the current transfer |
| tc | output | 1 | Terminal-count pulse |

## Verification
The assertions check the invariants on every cycle. The address counter increments only on accepted steps. The page stays frozen while the carry enable is clear. The carry enable can only rise after a high-page write. Word-mode page increments keep bit 0. A terminal-count pulse lasts one cycle and leaves the channel halted, with the count frozen until the next load.

Only the bench scenarios can show the full physical address at each step. They cover both bit mappings, the exact step on which tc appears, page carries that ripple into the high page, the precedence between a page write and a high-page write in the same cycle, and steps dropped because they collide with a register write.

// File: rtl/dma_ag_pkg.sv
package dma_ag_pkg;
  typedef enum logic {
    XFER_BYTE = 1'b0,
    XFER_WORD = 1'b1
  } xfer_mode_e;
endpackage

// File: rtl/dma_ag_addr.sv
module dma_ag_addr #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_ok,
  output logic [ADDR_W-1:0] addr_q,
  output logic              wrap
);
  // the counter rolls over on this step
  assign wrap = step_ok && (&addr_q);

  always_ff @(posedge clk) begin
    if (rst)          addr_q <= '0;
    else if (load_en) addr_q <= load_val;
    else if (step_ok) addr_q <= addr_q + 1'b1;
  end

  assert_addr_inc_R4: assert property (@(posedge clk) disable iff (rst)
    step_ok |=> addr_q == $past(addr_q) + 1'b1);
endmodule

// File: rtl/dma_ag_page.sv
module dma_ag_page #(
  parameter int PAGE_W   = 8,
  parameter int HIPAGE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                word_mode,
  input  logic                page_wr_en,
  input  logic [PAGE_W-1:0]   page_wr_val,
  input  logic                hipage_wr_en,
  input  logic [HIPAGE_W-1:0] hipage_wr_val,
  input  logic                addr_wr_en,
  input  logic                wrap,
  output logic [PAGE_W-1:0]   page_q,
  output logic [HIPAGE_W-1:0] hipage_q,
  output logic                carry_en_q
);
  localparam int PG_W = PAGE_W + HIPAGE_W;

  logic [PG_W-1:0] pg_cur, pg_inc, pg_next;

  assign pg_cur  = {hipage_q, page_q};
  // +2 in word mode keeps bit 0, +1 in byte mode
  assign pg_inc  = {{(PG_W-2){1'b0}}, word_mode, ~word_mode};
  assign pg_next = pg_cur + pg_inc;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q     <= '0;
      hipage_q   <= '0;
      carry_en_q <= 1'b0;
    end else begin
      if (wrap && carry_en_q) begin
        {hipage_q, page_q} <= pg_next;
      end else begin
        if (page_wr_en)   page_q   <= page_wr_val;
        if (hipage_wr_en) hipage_q <= hipage_wr_val;
      end
      if (page_wr_en || addr_wr_en) carry_en_q <= 1'b0;
      else if (hipage_wr_en)        carry_en_q <= 1'b1;
    end
  end

  assert_page_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (!carry_en_q && !page_wr_en && !hipage_wr_en) |=> $stable({hipage_q, page_q}));

  assert_carry_arm_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(carry_en_q) |-> $past(hipage_wr_en) && !$past(page_wr_en) && !$past(addr_wr_en));

  assert_word_bit0_R8: assert property (@(posedge clk) disable iff (rst)
    (wrap && carry_en_q && word_mode) |=> page_q[0] == $past(page_q[0]));
endmodule

// File: rtl/dma_ag_count.sv
module dma_ag_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             step_ok,
  output logic [CNT_W-1:0] cnt_q,
  output logic             halted_q,
  output logic             tc_q
);
  logic last_step;
  assign last_step = step_ok && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      halted_q <= 1'b1;
      tc_q     <= 1'b0;
    end else begin
      tc_q <= last_step;
      if (load_en) begin
        cnt_q    <= load_val;
        halted_q <= 1'b0;
      end else if (step_ok) begin
        cnt_q <= cnt_q - 1'b1;
        if (last_step) halted_q <= 1'b1;
      end
    end
  end

  assert_tc_halts_R6: assert property (@(posedge clk) disable iff (rst)
    tc_q |-> halted_q);

  assert_tc_single_R5: assert property (@(posedge clk) disable iff (rst)
    tc_q |=> !tc_q);

  assert_halt_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (halted_q && !load_en) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_ag_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int CNT_W    = 16,
  parameter int PAGE_W   = 8,
  parameter int HIPAGE_W = 8,
  localparam int PHYS_W  = ADDR_W + PAGE_W + HIPAGE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mode_wr_en,
  input  logic                mode_wr_val,
  input  logic                addr_wr_en,
  input  logic [ADDR_W-1:0]   addr_wr_val,
  input  logic                cnt_wr_en,
  input  logic [CNT_W-1:0]    cnt_wr_val,
  input  logic                page_wr_en,
  input  logic [PAGE_W-1:0]   page_wr_val,
  input  logic                hipage_wr_en,
  input  logic [HIPAGE_W-1:0] hipage_wr_val,
  input  logic                step,
  output logic [PHYS_W-1:0]   phys_addr,
  output logic                tc
);
  xfer_mode_e          mode_q;
  logic                any_wr, step_ok, wrap, halted, carry_en;
  logic [ADDR_W-1:0]   addr_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [PAGE_W-1:0]   page_q;
  logic [HIPAGE_W-1:0] hipage_q;

  always_ff @(posedge clk) begin
    if (rst)             mode_q <= XFER_BYTE;
    else if (mode_wr_en) mode_q <= xfer_mode_e'(mode_wr_val);
  end

  assign any_wr  = mode_wr_en | addr_wr_en | cnt_wr_en | page_wr_en | hipage_wr_en;
  assign step_ok = step && !halted && !any_wr;

  dma_ag_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load_en(addr_wr_en), .load_val(addr_wr_val),
    .step_ok(step_ok), .addr_q(addr_q), .wrap(wrap)
  );

  dma_ag_page #(.PAGE_W(PAGE_W), .HIPAGE_W(HIPAGE_W)) u_page (
    .clk(clk), .rst(rst), .word_mode(mode_q == XFER_WORD),
    .page_wr_en(page_wr_en), .page_wr_val(page_wr_val),
    .hipage_wr_en(hipage_wr_en), .hipage_wr_val(hipage_wr_val),
    .addr_wr_en(addr_wr_en), .wrap(wrap),
    .page_q(page_q), .hipage_q(hipage_q), .carry_en_q(carry_en)
  );

  dma_ag_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_en(cnt_wr_en), .load_val(cnt_wr_val),
    .step_ok(step_ok), .cnt_q(cnt_q), .halted_q(halted), .tc_q(tc)
  );

  always_comb begin
    if (mode_q == XFER_WORD) phys_addr = {hipage_q, page_q[PAGE_W-1:1], addr_q, 1'b0};
    else                     phys_addr = {hipage_q, page_q, addr_q};
  end

  // a halted channel cannot reach its terminal count again
  assert_no_step_halted_R6: assert property (@(posedge clk) disable iff (rst)
    (halted && !cnt_wr_en) |=> !tc);
endmodule

// File: tb/dma_addr_gen_tb_top.sv
module dma_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_wr_en = 0, mode_wr_val = 0;
  logic        addr_wr_en = 0; logic [15:0] addr_wr_val = '0;
  logic        cnt_wr_en = 0;  logic [15:0] cnt_wr_val = '0;
  logic        page_wr_en = 0; logic [7:0]  page_wr_val = '0;
  logic        hipage_wr_en = 0; logic [7:0] hipage_wr_val = '0;
  logic        step = 0;
  logic [31:0] phys_addr;
  logic        tc;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  dma_addr_gen dut_i (
    .clk(clk), .rst(rst), .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
    .addr_wr_en(addr_wr_en), .addr_wr_val(addr_wr_val),
    .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val),
    .page_wr_en(page_wr_en), .page_wr_val(page_wr_val),
    .hipage_wr_en(hipage_wr_en), .hipage_wr_val(hipage_wr_val),
    .step(step), .phys_addr(phys_addr), .tc(tc)
  );

  task automatic check(string tag, logic [32:0] got, logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got tc=%0b addr=%h, expected tc=%0b addr=%h",
               tag, got[32], got[31:0], exp[32], exp[31:0]);
    end
  endtask

  task automatic wr_mode(input logic v);
    @(negedge clk) begin mode_wr_en = 1; mode_wr_val = v; end
    @(negedge clk) mode_wr_en = 0;
  endtask
  task automatic wr_addr(input logic [15:0] v);
    @(negedge clk) begin addr_wr_en = 1; addr_wr_val = v; end
    @(negedge clk) addr_wr_en = 0;
  endtask
  task automatic wr_cnt(input logic [15:0] v);
    @(negedge clk) begin cnt_wr_en = 1; cnt_wr_val = v; end
    @(negedge clk) cnt_wr_en = 0;
  endtask
  task automatic wr_page(input logic [7:0] v);
    @(negedge clk) begin page_wr_en = 1; page_wr_val = v; end
    @(negedge clk) page_wr_en = 0;
  endtask
  task automatic wr_hip(input logic [7:0] v);
    @(negedge clk) begin hipage_wr_en = 1; hipage_wr_val = v; end
    @(negedge clk) hipage_wr_en = 0;
  endtask

  // driver: one step strobe, expected result pushed to the scoreboard
  task automatic do_step(input logic [31:0] exp_addr, input logic exp_tc, input string tag);
    @(negedge clk) begin
      step = 1;
      exp_q.push_back({exp_tc, exp_addr});
      tag_q.push_back(tag);
    end
    @(negedge clk) step = 0;
  endtask

  // monitor: compares just after the edge that consumed the step
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) check(tag_q.pop_front(), {tc, phys_addr}, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      failures++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    @(negedge clk);
    check("R1 reset", {tc, phys_addr}, 33'h0);
    do_step(32'h0000_0000, 0, "R1 step ignored before count load");

    // byte mode, carry disabled: wraps inside the page
    wr_mode(0);
    wr_page(8'h34); wr_addr(16'hFFFE); wr_cnt(16'd3);
    @(negedge clk) check("R2 R11 byte mapping", {tc, phys_addr}, {1'b0, 32'h0034_FFFE});
    do_step(32'h0034_FFFF, 0, "R4 byte increment");
    do_step(32'h0034_0000, 0, "R7 wrap without carry");
    do_step(32'h0034_0001, 0, "R5 count");
    do_step(32'h0034_0002, 1, "R5 terminal count on last step");
    do_step(32'h0034_0002, 0, "R6 step ignored after tc");

    // byte mode with carry enabled by high page written last
    wr_page(8'h34); wr_addr(16'hFFFE); wr_cnt(16'd2); wr_hip(8'hAB);
    do_step(32'hAB34_FFFF, 0, "R8 byte pre-wrap");
    do_step(32'hAB35_0000, 0, "R8 byte page carry");
    do_step(32'hAB35_0001, 1, "R5 tc after carry");

    // word mode, carry cleared by page/address writes
    wr_mode(1);
    wr_page(8'h35); wr_addr(16'hFFFF); wr_cnt(16'd1);
    @(negedge clk) check("R3 R11 word mapping", {tc, phys_addr}, {1'b0, 32'hAB35_FFFE});
    do_step(32'hAB34_0000, 0, "R7 word wrap without carry");
    do_step(32'hAB34_0002, 1, "R4 word increment by two");

    // word mode with carry: page advances by two keeping bit 0
    wr_page(8'h35); wr_addr(16'hFFFF); wr_cnt(16'd1); wr_hip(8'hAB);
    do_step(32'hAB36_0000, 0, "R8 word page carry");
    do_step(32'hAB36_0002, 1, "R5 word tc");

    // carry ripples from page into high page
    wr_mode(0);
    wr_page(8'hFF); wr_addr(16'hFFFF); wr_cnt(16'd0); wr_hip(8'h01);
    do_step(32'h0200_0000, 1, "R8 carry into high page, single transfer");

    // simultaneous page and high-page write: clear wins
    wr_addr(16'hFFFF); wr_cnt(16'd1); wr_hip(8'h05);
    @(negedge clk) begin
      page_wr_en = 1; page_wr_val = 8'h10;
      hipage_wr_en = 1; hipage_wr_val = 8'h05;
    end
    @(negedge clk) begin page_wr_en = 0; hipage_wr_en = 0; end
    do_step(32'h0510_0000, 0, "R9 carry cleared by page write");
    do_step(32'h0510_0001, 1, "R9 tc");

    // step colliding with a register write is dropped
    wr_addr(16'h0100); wr_cnt(16'd1);
    @(negedge clk) begin
      step = 1; mode_wr_en = 1; mode_wr_val = 0;
      exp_q.push_back({1'b0, 32'h0510_0100});
      tag_q.push_back("R10 step with write ignored");
    end
    @(negedge clk) begin step = 0; mode_wr_en = 0; end
    do_step(32'h0510_0101, 0, "R10 next step accepted");
    do_step(32'h0510_0102, 1, "R10 count intact");

    repeat (3) @(negedge clk);
    check("R6 tc low after pulse", {tc, 32'h0}, 33'h0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule